// File: doc/BRIEF.md
# Sliding-Window GPIO Port Register File

This block is the register store that sits behind a serial GPIO expander. The serial front end turns bus traffic into byte accesses. Each access carries an 8-bit register address, a write strobe with a data byte, and a read strobe. The block answers a read with one byte of read data, registered one cycle later. Its state is as follows. Each existing port has a 2-bit mode field and an output latch. There is one configuration register with a run bit and a transition-detect enable bit. Whenever the run bit is clear, the block is in shutdown. The block drives output-enable, output-value and pullup-enable for every port and reads back the live input level of every port.

Ports are numbered 0 to 31, and only ports 4 to 31 exist. Port data can be reached in two ways. A single-port address reaches exactly one port through data bit 0. A window address reaches eight consecutive ports that start at any port number, with no alignment. Window bits that land on ports below 4 or past port 31 are dropped on write and read back as zero. The transition detector, the serial front end and the pad drivers are neighbours of this block and are not part of it. The detector reads the enable bit from `detect_en`.

Top module: `gpio_window_regfile`

## Requirements
- R1: After reset, every existing port is in mode 10, every output latch is 0, and the configuration register is 0x00, so the block is in shutdown. Every mode register reads 0xAA, and `port_oe`, `port_out`, `port_pu`, `rdata` and `detect_en` are all 0.
- R2: Mode registers sit at addresses 0x09 to 0x0F. Register 0x09+i holds ports 4+4i to 7+4i, two bits per port. The lowest-numbered port is in bits 1:0 and the highest in bits 7:6. Reads return what was written.
- R3: Mode 01 is a push-pull output: `port_oe` is 1 and `port_pu` is 0. Mode 10 is an input with no pullup, mode 11 is an input with the pullup on, and the reserved mode 00 drives nothing. `port_oe` and `port_pu` are never 1 together.
- R4: Address 0x20+p, for p from 4 to 31, writes data bit 0 into the output latch of port p. `port_out[p]` follows that latch. A read returns the port value in bit 0, with bits 7:1 at zero.
- R5: Addresses 0x20 to 0x23 reach the virtual ports 0 to 3. Writes to them change nothing, and reads return 0x00. `port_oe`, `port_out` and `port_pu` bits 3:0 are always 0.
- R6: Address 0x40+k, for k from 0 to 31, maps data bit j to port k+j, for j from 0 to 7. Bits that map to a port below 4 or above 31 are dropped on write and read as 0.
- R7: The value read for a port is its output latch when the port is in mode 01. In any other mode it is the level on `pin_in` at the read.
- R8: The configuration register at 0x04 keeps bit 0 as the run bit and bit 7 as the detect enable, and drives `detect_en` from bit 7. Bits 6:1 always read as 0.
- R9: While the run bit is 0, `port_oe` and `port_pu` are all 0. Writes to the mode registers and to the latches are still accepted. Setting the run bit brings back the programmed directions, pullups and levels.
- R10: Address 0x00 and every other address not named above ignore writes and return 0x00 on a read.
- R11: `rdata` is loaded in the cycle after a read strobe and holds its value in cycles without one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe for the current address |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| pin_in | input | 32 | Sampled input level of ports 0 to 31 |
| port_oe | output | 32 | Output enable per port |
| port_out | output | 32 | Output latch value per port |
| port_pu | output | 32 | Pullup enable per port |
| detect_en | output | 1 | Transition-detect enable for the neighbouring detector |

## Verification
The bench targets windows that straddle the ends of the port range: start 2 runs into the virtual ports, and starts 29 and 31 run past port 31. A design that mis-clips them would corrupt real ports or report phantom bits. Shutdown is checked for programming that survives it. A design that cleared state on shutdown, or refused writes during it, would come back out of shutdown with the wrong directions or levels. The bench also mixes ports in output mode with ports in input mode inside one read, because a wrong source select would return the pin level where the latch was due. Undefined addresses, virtual ports, and `rdata` holding its value between reads are exercised under random traffic. Any stray decode would show as a change in the next output comparison.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;
  localparam int NPORT         = 32;
  localparam int PFIRST        = 4;
  localparam int WIN           = 8;
  localparam int DW            = 8;
  localparam int AW            = 8;
  localparam int PIDX_W        = $clog2(NPORT);
  localparam int WIN_W         = $clog2(WIN);
  localparam int PORTS_PER_REG = DW / 2;
  localparam int NMODE_REG     = (NPORT - PFIRST) / PORTS_PER_REG;

  localparam logic [AW-1:0] A_CFG     = 8'h04;
  localparam logic [AW-1:0] A_MODE0   = 8'h09;
  localparam logic [AW-1:0] A_SINGLE0 = 8'h20;
  localparam logic [AW-1:0] A_WIN0    = 8'h40;
  localparam logic [AW-1:0] A_MODE_END   = A_MODE0 + AW'(NMODE_REG);
  localparam logic [AW-1:0] A_SINGLE_END = A_SINGLE0 + AW'(NPORT);
  localparam logic [AW-1:0] A_WIN_END    = A_WIN0 + AW'(NPORT);

  typedef enum logic [1:0] {
    MODE_RSVD  = 2'b00,
    MODE_OUT   = 2'b01,
    MODE_IN    = 2'b10,
    MODE_IN_PU = 2'b11
  } pmode_e;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CFG,
    ACC_MODE,
    ACC_SINGLE,
    ACC_WIN
  } acc_e;

  typedef struct packed {
    acc_e              kind;
    logic [PIDX_W-1:0] idx;
  } dec_t;
endpackage

// File: rtl/gpio_rf_rstsync.sv
module gpio_rf_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_rf_decode.sv
module gpio_rf_decode
  import gpio_rf_pkg::*;
(
  input  logic [AW-1:0] addr,
  output dec_t          dec
);
  logic [AW-1:0] off_mode;
  logic [AW-1:0] off_single;
  logic [AW-1:0] off_win;

  always_comb begin
    off_mode   = addr - A_MODE0;
    off_single = addr - A_SINGLE0;
    off_win    = addr - A_WIN0;
    dec.kind   = ACC_NONE;
    dec.idx    = '0;
    if (addr == A_CFG) begin
      dec.kind = ACC_CFG;
    end else if (addr >= A_MODE0 && addr < A_MODE_END) begin
      dec.kind = ACC_MODE;
      dec.idx  = off_mode[PIDX_W-1:0];
    end else if (addr >= A_SINGLE0 && addr < A_SINGLE_END) begin
      dec.kind = ACC_SINGLE;
      dec.idx  = off_single[PIDX_W-1:0];
    end else if (addr >= A_WIN0 && addr < A_WIN_END) begin
      dec.kind = ACC_WIN;
      dec.idx  = off_win[PIDX_W-1:0];
    end
  end
endmodule

// File: rtl/gpio_rf_port_cell.sv
module gpio_rf_port_cell
  import gpio_rf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [1:0] mode_wd,
  input  logic       lat_we,
  input  logic       lat_wd,
  input  logic       shutdown,
  input  logic       pin,
  output pmode_e     mode,
  output logic       lat,
  output logic       oe,
  output logic       pu,
  output logic       rbit
);
  pmode_e mode_q, mode_d;
  logic   lat_q, lat_d;

  always_comb begin
    mode_d = mode_q;
    lat_d  = lat_q;
    if (mode_we) mode_d = pmode_e'(mode_wd);
    if (lat_we)  lat_d  = lat_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IN;
      lat_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      lat_q  <= lat_d;
    end
  end

  assign mode = mode_q;
  assign lat  = lat_q;
  assign oe   = !shutdown && (mode_q == MODE_OUT);
  assign pu   = !shutdown && (mode_q == MODE_IN_PU);
  assign rbit = (mode_q == MODE_OUT) ? lat_q : pin;

  // R3
  input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IN || mode_q == MODE_RSVD) |-> (!oe && !pu));

  // R2
  mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode == pmode_e'($past(mode_wd))));
endmodule

// File: rtl/gpio_rf_rdmux.sv
module gpio_rf_rdmux
  import gpio_rf_pkg::*;
(
  input  dec_t             dec,
  input  logic             cfg_m,
  input  logic             cfg_s,
  input  pmode_e           mode_arr [NPORT],
  input  logic [NPORT-1:0] rbit,
  output logic [DW-1:0]    rd_val
);
  logic [PIDX_W:0] pos;
  logic [PIDX_W:0] mp;

  always_comb begin
    rd_val = '0;
    pos    = '0;
    mp     = '0;
    unique case (dec.kind)
      ACC_CFG: begin
        rd_val[DW-1] = cfg_m;
        rd_val[0]    = cfg_s;
      end
      ACC_MODE: begin
        for (int s = 0; s < PORTS_PER_REG; s++) begin
          mp = (PIDX_W+1)'(PFIRST) + ({1'b0, dec.idx} << $clog2(PORTS_PER_REG))
               + (PIDX_W+1)'(s);
          if (mp < (PIDX_W+1)'(NPORT))
            rd_val[2*s +: 2] = mode_arr[mp[PIDX_W-1:0]];
        end
      end
      ACC_SINGLE: begin
        rd_val[0] = rbit[dec.idx];
      end
      ACC_WIN: begin
        for (int j = 0; j < WIN; j++) begin
          pos = {1'b0, dec.idx} + (PIDX_W+1)'(j);
          if (pos < (PIDX_W+1)'(NPORT))
            rd_val[j] = rbit[pos[PIDX_W-1:0]];
        end
      end
      default: rd_val = '0;
    endcase
  end
endmodule

// File: rtl/gpio_window_regfile.sv
module gpio_window_regfile
  import gpio_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NPORT-1:0] pin_in,
  output logic [NPORT-1:0] port_oe,
  output logic [NPORT-1:0] port_out,
  output logic [NPORT-1:0] port_pu,
  output logic             detect_en
);
  logic             rst_q;
  dec_t             dec;
  logic             cfg_m_q, cfg_m_d;
  logic             cfg_s_q, cfg_s_d;
  logic             shutdown;
  pmode_e           mode_arr [NPORT];
  logic [NPORT-1:0] rbit;
  logic [DW-1:0]    rd_val;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic             unused_low_pins;

  gpio_rf_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q)
  );

  gpio_rf_decode u_dec (
    .addr (addr),
    .dec  (dec)
  );

  // configuration register
  always_comb begin
    cfg_m_d = cfg_m_q;
    cfg_s_d = cfg_s_q;
    if (wr_en && dec.kind == ACC_CFG) begin
      cfg_m_d = wdata[DW-1];
      cfg_s_d = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cfg_m_q <= 1'b0;
      cfg_s_q <= 1'b0;
    end else begin
      cfg_m_q <= cfg_m_d;
      cfg_s_q <= cfg_s_d;
    end
  end

  assign shutdown  = !cfg_s_q;
  assign detect_en = cfg_m_q;

  assign unused_low_pins = ^pin_in[PFIRST-1:0];

  // per-port state and write steering
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    if (p >= PFIRST) begin : g_live
      localparam int MREG = (p - PFIRST) / PORTS_PER_REG;
      localparam int SLOT = (p - PFIRST) % PORTS_PER_REG;
      logic            mwe;
      logic [1:0]      mwd;
      logic            lwe;
      logic            lwd;
      logic [PIDX_W:0] woff;
      logic            in_win;

      always_comb begin
        woff   = (PIDX_W+1)'(p) - {1'b0, dec.idx};
        in_win = ({1'b0, dec.idx} <= (PIDX_W+1)'(p)) && (woff < (PIDX_W+1)'(WIN));
        mwe    = wr_en && (dec.kind == ACC_MODE) && (dec.idx == PIDX_W'(MREG));
        mwd    = wdata[2*SLOT +: 2];
        lwe    = wr_en && (((dec.kind == ACC_SINGLE) && (dec.idx == PIDX_W'(p)))
                        || ((dec.kind == ACC_WIN) && in_win));
        lwd    = (dec.kind == ACC_WIN) ? wdata[woff[WIN_W-1:0]] : wdata[0];
      end

      gpio_rf_port_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_q),
        .mode_we  (mwe),
        .mode_wd  (mwd),
        .lat_we   (lwe),
        .lat_wd   (lwd),
        .shutdown (shutdown),
        .pin      (pin_in[p]),
        .mode     (mode_arr[p]),
        .lat      (port_out[p]),
        .oe       (port_oe[p]),
        .pu       (port_pu[p]),
        .rbit     (rbit[p])
      );
    end else begin : g_virtual
      assign mode_arr[p] = MODE_RSVD;
      assign port_out[p] = 1'b0;
      assign port_oe[p]  = 1'b0;
      assign port_pu[p]  = 1'b0;
      assign rbit[p]     = 1'b0;
    end
  end

  gpio_rf_rdmux u_rdmux (
    .dec      (dec),
    .cfg_m    (cfg_m_q),
    .cfg_s    (cfg_s_q),
    .mode_arr (mode_arr),
    .rbit     (rbit),
    .rd_val   (rd_val)
  );

  // registered read data
  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R9
  shutdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !cfg_s_q |-> (port_oe == '0 && port_pu == '0));

  // R3
  oe_pu_excl_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (port_oe & port_pu) == '0);

  // R5
  virtual_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (port_oe[PFIRST-1:0] == '0) && (port_out[PFIRST-1:0] == '0)
    && (port_pu[PFIRST-1:0] == '0));

  // R4
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && dec.kind == ACC_SINGLE && dec.idx >= PIDX_W'(PFIRST))
    |=> (port_out[$past(dec.idx)] == $past(wdata[0])));

  // R6
  window_head_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && dec.kind == ACC_WIN && dec.idx >= PIDX_W'(PFIRST))
    |=> (port_out[$past(dec.idx)] == $past(wdata[0])));

  // R10
  undef_read_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && dec.kind == ACC_NONE) |=> (rdata == '0));

  // R8
  cfg_gap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && dec.kind == ACC_CFG) |=> (rdata[DW-2:1] == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/gpio_window_regfile_test.sv
module gpio_window_regfile_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr, wdata, rdata;
  logic [31:0] pin_in, port_oe, port_out, port_pu;
  logic        detect_en;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int          md [32];
  bit          lt [32];
  bit          ref_m, ref_s;
  logic [7:0]  exp_rd;

  gpio_window_regfile uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .port_oe(port_oe),
    .port_out(port_out), .port_pu(port_pu), .detect_en(detect_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic bit port_val(input int p);
    if (p < 4 || p > 31) return 1'b0;
    return (md[p] == 1) ? lt[p] : pin_in[p];
  endfunction

  function automatic logic [7:0] model_read(input int a);
    logic [7:0] r = 8'h00;
    if (a == 4) r = {ref_m, 6'b0, ref_s};
    else if (a >= 9 && a <= 15)
      for (int s = 0; s < 4; s++) r[2*s +: 2] = 2'(md[4 + (a - 9) * 4 + s]);
    else if (a >= 32 && a <= 63) r[0] = port_val(a - 32);
    else if (a >= 64 && a <= 95)
      for (int j = 0; j < 8; j++) r[j] = port_val(a - 64 + j);
    return r;
  endfunction

  task automatic model_write(input int a, input logic [7:0] d);
    if (a == 4) begin ref_m = d[7]; ref_s = d[0]; end
    else if (a >= 9 && a <= 15)
      for (int s = 0; s < 4; s++) md[4 + (a - 9) * 4 + s] = int'(d[2*s +: 2]);
    else if (a >= 36 && a <= 63) lt[a - 32] = d[0];
    else if (a >= 64 && a <= 95)
      for (int j = 0; j < 8; j++)
        if (a - 64 + j >= 4 && a - 64 + j <= 31) lt[a - 64 + j] = d[j];
  endtask

  task automatic check_outs(input string req);
    logic [31:0] eo, ev, ep;
    eo = '0; ev = '0; ep = '0;
    for (int p = 4; p < 32; p++) begin
      eo[p] = ref_s && (md[p] == 1);
      ep[p] = ref_s && (md[p] == 3);
      ev[p] = lt[p];
    end
    chk(port_oe == eo, req, "port_oe", port_oe, eo);
    chk(port_out == ev, req, "port_out", port_out, ev);
    chk(port_pu == ep, req, "port_pu", port_pu, ep);
    chk(detect_en == ref_m, req, "detect_en", 32'(detect_en), 32'(ref_m));
    chk(rdata == exp_rd, req, "rdata", 32'(rdata), 32'(exp_rd));
  endtask

  task automatic op(input bit w, input bit r, input logic [7:0] a,
                    input logic [7:0] d, input string req);
    logic [7:0] e;
    wr_en = w; rd_en = r; addr = a; wdata = d;
    e = model_read(int'(a));
    @(posedge clk);
    if (w) model_write(int'(a), d);
    if (r) exp_rd = e;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check_outs(req);
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    op(1'b0, 1'b1, a, 8'h00, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
    op(1'b1, 1'b0, a, d, req);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 32; p++) begin md[p] = 2; lt[p] = 1'b0; end
    ref_m = 1'b0; ref_s = 1'b0; exp_rd = 8'h00;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    pin_in = 32'h0000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_outs("R1");
    for (int a = 9; a <= 15; a++) rd(8'(a), "R1");
    rd(8'h04, "R1");

    // R8 run bit and detect enable; gap bits read zero
    wr(8'h04, 8'hFF, "R8");
    rd(8'h04, "R8");
    wr(8'h04, 8'h01, "R8");

    // R2 / R3 mode packing and codes
    wr(8'h09, 8'h55, "R2");
    wr(8'h0F, 8'hE4, "R3");
    rd(8'h09, "R2");
    rd(8'h0F, "R2");

    // R4 single-port writes and reads
    pin_in = 32'h0000_1000;
    wr(8'h24, 8'h01, "R4");
    wr(8'h25, 8'hFE, "R4");
    rd(8'h24, "R4");
    rd(8'h2C, "R7");
    rd(8'h3D, "R4");

    // R5 virtual ports
    wr(8'h21, 8'hFF, "R5");
    wr(8'h23, 8'hFF, "R5");
    rd(8'h21, "R5");
    rd(8'h43, "R5");

    // R6 windows straddling the range ends
    wr(8'h0A, 8'h55, "R6");
    wr(8'h42, 8'hA5, "R6");
    rd(8'h42, "R6");
    wr(8'h5D, 8'hFF, "R6");
    rd(8'h5D, "R6");
    wr(8'h5F, 8'h00, "R6");
    rd(8'h5F, "R6");
    wr(8'h47, 8'h3C, "R6");
    rd(8'h47, "R6");

    // R7 mixed outputs and inputs in one window
    pin_in = 32'hA5C3_F00F;
    rd(8'h50, "R7");
    rd(8'h46, "R7");
    wr(8'h0E, 8'h5A, "R7");
    rd(8'h58, "R7");

    // R9 shutdown keeps and accepts programming
    wr(8'h04, 8'h80, "R9");
    wr(8'h24, 8'h00, "R9");
    wr(8'h0B, 8'hFF, "R9");
    rd(8'h0B, "R9");
    wr(8'h04, 8'h01, "R9");
    rd(8'h04, "R9");

    // R10 undefined addresses and no-op
    wr(8'h00, 8'hFF, "R10");
    wr(8'h05, 8'hFF, "R10");
    wr(8'h08, 8'h00, "R10");
    wr(8'h60, 8'hFF, "R10");
    wr(8'h7F, 8'hFF, "R10");
    rd(8'h00, "R10");
    rd(8'h07, "R10");
    rd(8'h10, "R10");
    rd(8'hC4, "R10");

    // R11 read data holds between reads
    rd(8'h09, "R11");
    wr(8'h09, 8'hFF, "R11");
    op(1'b0, 1'b0, 8'h04, 8'h00, "R11");

    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      int pick;
      pin_in = $urandom;
      pick = $urandom_range(0, 9);
      if (pick == 0)      a = 8'h04;
      else if (pick < 3)  a = 8'(8'h09 + $urandom_range(0, 6));
      else if (pick < 5)  a = 8'(8'h20 + $urandom_range(0, 31));
      else if (pick < 8)  a = 8'(8'h40 + $urandom_range(0, 31));
      else                a = 8'($urandom_range(0, 255));
      op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, 8'($urandom), "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule